// File: doc/BRIEF.md
# Byte-Stream Pattern Abort Detector

This block sits beside a DMA channel's data path and watches each byte the channel moves. When the programmed pattern shows up, it raises a one-cycle match pulse and a request to clear the channel's enable. It then refuses further bytes until the channel is restarted. The pattern is either a single byte or two consecutive bytes. An optional ignore value turns any incoming byte equal to it into a wildcard at its position.

Bytes arrive on a valid/ready stream. A byte is taken on a rising edge where `in_valid_i` and `in_ready_o` are both high. `in_ready_o` drops after a match and stays low until `clr_i`. It is also low in any cycle where `clr_i` is high. A source seeing ready low must hold its byte. The block never takes a byte while ready is low. `clr_i` is pulsed when a new transfer starts. It empties the byte history and releases the halt.

Top module: `pm_abort_detector`

## Requirements
- R1: After reset, `match_o` and `chan_en_clr_o` are 0 and `in_ready_o` is 1.
- R2: With `pm_en_i` at 0, no accepted byte ever produces `match_o` or `chan_en_clr_o`.
- R3: With `len_sel_i` at 0 (one-byte mode), an accepted byte matches when it equals `pattern_i[7:0]`.
- R4: With `len_sel_i` at 1 (two-byte mode), a match needs two conditions. The previously accepted byte must equal `pattern_i[7:0]`, and the byte accepted now must equal `pattern_i[15:8]`.
- R5: In two-byte mode, no match occurs until at least two bytes have been accepted since the last reset or `clr_i`.
- R6: With `ign_en_i` at 1, a byte equal to `ign_byte_i` satisfies its pattern position whatever the pattern holds there.
- R7: A match raises `match_o` and `chan_en_clr_o` together. They rise in the cycle after the accepting edge and stay high for exactly one cycle.
- R8: After a match, `in_ready_o` stays 0 and no byte is accepted until `clr_i` is asserted.
- R9: `clr_i` empties the history and releases the halt. `in_ready_o` is 0 in any cycle where `clr_i` is high, so a byte offered then is neither evaluated nor stored.
- R10: The history changes only on accepted bytes. Idle cycles between two bytes do not break a two-byte match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Transfer restart: empties history, releases halt |
| pm_en_i | input | 1 | Pattern-match abort enable |
| len_sel_i | input | 1 | 0 = one-byte pattern, 1 = two-byte pattern |
| pattern_i | input | 16 | Pattern; [7:0] earlier byte, [15:8] later byte |
| ign_en_i | input | 1 | Ignore-value enable |
| ign_byte_i | input | 8 | Byte value treated as wildcard |
| in_valid_i | input | 1 | Byte valid |
| in_data_i | input | 8 | Byte data |
| in_ready_o | output | 1 | Byte can be accepted |
| match_o | output | 1 | One-cycle match pulse |
| chan_en_clr_o | output | 1 | One-cycle request to clear channel enable |

## Verification
Restart and byte acceptance can fall in the same cycle: `clr_i` may be high while a byte is offered. The bench provokes this by offering the pattern's low byte in one-byte mode with `clr_i` high. It expects ready low in that cycle and no match after it. It then offers the high byte alone in two-byte mode and expects no match, which shows the colliding byte was never stored. A match and the arrival of the next byte also compete: after every match, the bench checks that the next offered byte sees ready low and that the pulse has already ended.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic {
    PM_LEN_ONE = 1'b0,
    PM_LEN_TWO = 1'b1
  } pm_len_e;
endpackage

// File: rtl/pm_lane_cmp.sv
module pm_lane_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] byte_i,
  input  logic [W-1:0] pat_i,
  input  logic [W-1:0] ign_i,
  input  logic         ign_en_i,
  output logic         hit_o
);
  always_comb begin
    hit_o = (byte_i == pat_i) || (ign_en_i && (byte_i == ign_i));
  end
endmodule

// File: rtl/pm_history.sv
module pm_history #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               shift_i,
  input  logic [W-1:0]       byte_i,
  output logic [DEPTH*W-1:0] hist_o,
  output logic               full_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr_i) begin
      cnt <= '0;
    end else if (shift_i && (cnt != FULL_CNT)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign full_o = (cnt == FULL_CNT);

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [W-1:0] nxt;
    if (i == DEPTH - 1) begin : g_top
      assign nxt = byte_i;
    end else begin : g_mid
      assign nxt = hist_o[(i+1)*W +: W];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hist_o[i*W +: W] <= '0;
      end else if (shift_i) begin
        hist_o[i*W +: W] <= nxt;
      end
    end
  end

  // R9: clear empties the history count
  assert_clr_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt == '0));
  // R10: no accepted byte, no change
  assert_hist_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_i |=> $stable(hist_o));
endmodule

// File: rtl/pm_abort_detector.sv
module pm_abort_detector
  import pm_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int PAT_BYTES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr_i,
  input  logic                          pm_en_i,
  input  logic                          len_sel_i,
  input  logic [BYTE_W*PAT_BYTES-1:0]   pattern_i,
  input  logic                          ign_en_i,
  input  logic [BYTE_W-1:0]             ign_byte_i,
  input  logic                          in_valid_i,
  input  logic [BYTE_W-1:0]             in_data_i,
  output logic                          in_ready_o,
  output logic                          match_o,
  output logic                          chan_en_clr_o
);
  localparam int HIST = PAT_BYTES - 1;

  logic                     accept;
  logic                     halted;
  logic                     match_q;
  logic                     hist_full;
  logic [HIST*BYTE_W-1:0]   hist;
  logic [PAT_BYTES-1:0]     lane_hit;
  logic                     single_hit;
  logic                     raw_match;
  pm_len_e                  len_mode;

  assign len_mode   = pm_len_e'(len_sel_i);
  assign in_ready_o = !halted && !clr_i;
  assign accept     = in_valid_i && in_ready_o;

  pm_history #(.W(BYTE_W), .DEPTH(HIST)) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr_i),
    .shift_i (accept),
    .byte_i  (in_data_i),
    .hist_o  (hist),
    .full_o  (hist_full)
  );

  for (genvar k = 0; k < PAT_BYTES; k++) begin : g_lane
    logic [BYTE_W-1:0] win_byte;
    if (k == PAT_BYTES - 1) begin : g_cur
      assign win_byte = in_data_i;
    end else begin : g_old
      assign win_byte = hist[k*BYTE_W +: BYTE_W];
    end
    pm_lane_cmp #(.W(BYTE_W)) u_cmp (
      .byte_i   (win_byte),
      .pat_i    (pattern_i[k*BYTE_W +: BYTE_W]),
      .ign_i    (ign_byte_i),
      .ign_en_i (ign_en_i),
      .hit_o    (lane_hit[k])
    );
  end

  pm_lane_cmp #(.W(BYTE_W)) u_single (
    .byte_i   (in_data_i),
    .pat_i    (pattern_i[BYTE_W-1:0]),
    .ign_i    (ign_byte_i),
    .ign_en_i (ign_en_i),
    .hit_o    (single_hit)
  );

  always_comb begin
    if (len_mode == PM_LEN_TWO) raw_match = hist_full && (&lane_hit);
    else                        raw_match = single_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      halted  <= 1'b0;
    end else if (clr_i) begin
      match_q <= 1'b0;
      halted  <= 1'b0;
    end else begin
      match_q <= accept && pm_en_i && raw_match;
      if (accept && pm_en_i && raw_match) halted <= 1'b1;
    end
  end

  assign match_o       = match_q;
  assign chan_en_clr_o = match_q;

  assert_pulse_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |=> !match_o);
  assert_no_match_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> $past(pm_en_i));
  assert_halt_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> !in_ready_o);
  assert_two_byte_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && $past(len_sel_i)) |-> $past(hist_full));
  assert_match_needs_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> ($past(in_valid_i) && $past(in_ready_o)));
endmodule

// File: tb/tb_pm_abort_detector.sv
module tb_pm_abort_detector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        en = 1'b0;
  logic        len = 1'b0;
  logic [15:0] pat = 16'hA53C;
  logic        ig = 1'b0;
  logic [7:0]  ign = 8'h7E;
  logic        valid = 1'b0;
  logic [7:0]  data = 8'h00;
  logic        ready, match, cen;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_prev;
  logic       m_full;
  logic       m_halt;

  always #10 clk = ~clk;

  pm_abort_detector dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .pm_en_i(en), .len_sel_i(len),
    .pattern_i(pat), .ign_en_i(ig), .ign_byte_i(ign), .in_valid_i(valid),
    .in_data_i(data), .in_ready_o(ready), .match_o(match), .chan_en_clr_o(cen)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic hit(input logic [7:0] b, input logic [7:0] p);
    return (b == p) || (ig && b == ign);
  endfunction

  function automatic logic [7:0] sym(input int i);
    case (i)
      0: return 8'h3C;
      1: return 8'hA5;
      2: return 8'h7E;
      default: return 8'h11;
    endcase
  endfunction

  task automatic send(input logic [7:0] b, input string tag);
    logic acc, em;
    @(negedge clk);
    chk(match == 1'b0 && cen == 1'b0, "R7 pulse ended", match, 0);
    valid = 1'b1; data = b;
    #1;
    chk(ready == !m_halt, "R8 ready", ready, !m_halt);
    acc = !m_halt;
    em = acc && en && (len ? (m_full && hit(m_prev, pat[7:0]) && hit(b, pat[15:8]))
                           : hit(b, pat[7:0]));
    @(posedge clk);
    @(negedge clk);
    chk(match == em, tag, match, em);
    chk(cen == em, "R7 clear request", cen, em);
    valid = 1'b0;
    if (acc) begin m_prev = b; m_full = 1'b1; end
    if (em) m_halt = 1'b1;
  endtask

  task automatic do_clr();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    m_full = 1'b0; m_halt = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_prev = 8'h00; m_full = 1'b0; m_halt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(match == 0 && cen == 0, "R1 outputs", match, 0);
    chk(ready == 1, "R1 ready", ready, 1);

    // near-exhaustive sweep: enable x length x ignore x all byte pairs
    for (int e = 0; e < 2; e++)
      for (int l = 0; l < 2; l++)
        for (int g = 0; g < 2; g++)
          for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++) begin
              en = e[0]; len = l[0]; ig = g[0];
              do_clr();
              send(sym(i), e == 0 ? "R2" : (l == 1 ? "R5 first byte" :
                           (g == 1 ? "R6 one-byte" : "R3")));
              send(sym(j), e == 0 ? "R2" : (g == 1 ? "R6" : (l == 1 ? "R4" : "R3")));
            end

    // R10: idle cycles between the two bytes keep the history
    en = 1; len = 1; ig = 0;
    do_clr();
    send(8'h3C, "R10 first");
    repeat (3) @(negedge clk);
    send(8'hA5, "R10 match across idle");
    send(8'h3C, "R8 halted");
    send(8'hA5, "R8 halted");

    // R5: after clear, a lone high byte does not match
    do_clr();
    send(8'hA5, "R5 one byte only");

    // R9: clear collides with an offered byte
    len = 0;
    do_clr();
    @(negedge clk);
    clr = 1'b1; valid = 1'b1; data = 8'h3C;
    #1;
    chk(ready == 0, "R9 ready low during clear", ready, 0);
    @(negedge clk);
    clr = 1'b0; valid = 1'b0;
    chk(match == 0, "R9 colliding byte not evaluated", match, 0);
    m_full = 1'b0; m_halt = 1'b0;
    len = 1;
    send(8'hA5, "R9 colliding byte not stored");
    send(8'h3C, "R4");
    send(8'hA5, "R4 match after collision");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule